// File: doc/BRIEF.md
# Double-Buffered Command Fetch DMA

This block streams 64-bit command words from one of two memory ports into a downstream command FIFO. Software programs it through a small register write port: a start-address write arms a transfer without moving any data, and an end-address write launches it. The end address is exclusive, so equal start and end addresses give a valid empty transfer that a later end write can extend.

One transfer can wait behind the running one. An end write with no start armed pushes the end of the live (or already finished) transfer further out, so a producer can append commands while the engine trails behind it. An end write with a start armed either launches at once, when the engine is idle, or queues the transfer, which then begins by itself as soon as the running transfer reaches its end. A freeze control pauses fetching, and a flush control cuts the running transfer short. A source bit selects which memory port supplies the words, and a full FIFO stalls the fetch.

Top module: `cmd_fetch_dma`

## Requirements
- R1: After a synchronous active-low reset the start, end and current readbacks are zero, both pending flags, freeze, flush, source and busy are low, and no memory request is made.
- R2: Addresses are 24 bits. Written address bits 2:0 are discarded and read back as zero on start_rd and end_rd, so every fetch address is a multiple of 8.
- R3: A write with cfg_sel=0 (start) latches the start address and sets start_pending without issuing any fetch. A second start write while start_pending is set replaces the armed value.
- R4: A write with cfg_sel=1 (end) while start_pending is set, no transfer is running, and neither freeze nor flush is set, loads cur_rd with the armed start on the next edge and clears start_pending. If start equals end, no word is fetched and dma_busy stays low.
- R5: Each cycle with a request accepted (mem_req and mem_ack on the selected port and fifo_full low) pushes the returned word to the FIFO at address cur_rd and advances cur_rd by 8. Fetching stops when cur_rd reaches the end, which is excluded.
- R6: An end write with start_pending clear changes the end of the current or finished transfer, and fetching continues from cur_rd up to the new end.
- R7: An end write with start_pending set while a transfer is running, frozen or flushed sets end_pending. Further end writes only change the queued end. When the running transfer is done and neither freeze nor flush is set, the queued transfer begins from the armed start to the last written end and both flags clear. end_pending never stands without start_pending.
- R8: start_rd and end_rd return the most recently written start and end values. cur_rd always belongs to the running or last finished transfer.
- R9: While freeze is set no word is fetched and nothing launches. cur_rd holds and fetching resumes from it once freeze clears. Start and end writes made during freeze still update the pending flags.
- R10: Setting flush ends the running transfer at its present cur_rd. While flush is set, no word is fetched and no queued transfer starts.
- R11: Control writes use cfg_sel=2 with data bits 0/1 setting/clearing the source, 2/3 setting/clearing freeze and 4/5 setting/clearing flush (set wins over clear). Source 0 routes the request to port 0 (mem_req[0], mem_rdata_a) and source 1 to port 1 (mem_req[1], mem_rdata_b). No request is made while fifo_full is high.
- R12: dma_busy is high exactly when cur_rd is below the active end and neither freeze nor flush is set, whatever fifo_full is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 start, 1 end, 2 control, 3 ignored |
| cfg_wdata | input | 24 | Register write data |
| start_rd | output | 24 | Last written start address |
| end_rd | output | 24 | Last written end address |
| cur_rd | output | 24 | Address of the next word to fetch |
| start_pending | output | 1 | A start address is armed |
| end_pending | output | 1 | A full transfer is queued |
| dma_busy | output | 1 | Transfer active and not held |
| freeze_st | output | 1 | Freeze control state |
| flush_st | output | 1 | Flush control state |
| src_st | output | 1 | Selected memory port |
| mem_req | output | 2 | Fetch request, one bit per memory port |
| mem_addr | output | 24 | Fetch address, shared by both ports |
| mem_ack | input | 2 | Request accepted with data, one bit per port |
| mem_rdata_a | input | 64 | Word returned by port 0 |
| mem_rdata_b | input | 64 | Word returned by port 1 |
| fifo_full | input | 1 | Downstream FIFO has no free space |
| fifo_push | output | 1 | Push a word into the FIFO |
| fifo_wdata | output | 64 | Word pushed into the FIFO |

## Verification
The bench targets the hand-off points of the pending logic. These are an end write arriving while a transfer is still running, which a faulty design would launch at once and lose the running tail, and a queued end rewritten twice, where a faulty design would fetch to the stale end. Freeze and flush are tested with writes made during the hold. A design that launched under freeze, or let flush fall through to a queued transfer, would push words early or skip the queued transfer. Zero-length transfers, the exclusive end, discarded low address bits, source switching mid-stream and FIFO backpressure are also tested. Errors there show as an extra or missing word, a wrong source tag, or a request while the FIFO is full.

// File: rtl/cfd_pkg.sv
// Shared constants and types for the command fetch DMA.
// Assumes a byte-addressed 24-bit space and 8-byte command words.
package cfd_pkg;
    localparam int ADDR_W   = 24;
    localparam int WORD_W   = 64;
    localparam int ALIGN_W  = 3;
    localparam int N_SRC    = 2;

    // register select encoding on the write port
    typedef enum logic [1:0] {
        SEL_START = 2'd0,
        SEL_END   = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_NONE  = 2'd3
    } cfg_sel_e;

    // control write bit positions (set/clear pairs)
    localparam int CB_SRC_SET = 0;
    localparam int CB_SRC_CLR = 1;
    localparam int CB_FRZ_SET = 2;
    localparam int CB_FRZ_CLR = 3;
    localparam int CB_FLS_SET = 4;
    localparam int CB_FLS_CLR = 5;
endpackage

// File: rtl/cfd_regfile.sv
// Programmer-visible registers and the pending-transfer decisions.
// Holds armed start, last written end, pending flags and control bits;
// decides when an end write or a queued transfer launches and when an
// end write extends the live transfer. Assumes 'running' comes from the
// fetch engine registers (no combinational path back into it).
module cfd_regfile #(
    parameter int AW  = cfd_pkg::ADDR_W,
    parameter int LSB = cfd_pkg::ALIGN_W,
    localparam int WA = AW - LSB
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          running,
    output logic [WA-1:0] start_w,
    output logic [WA-1:0] end_w,
    output logic          start_pend,
    output logic          end_pend,
    output logic          freeze,
    output logic          flush,
    output logic          src,
    output logic          launch,
    output logic [WA-1:0] launch_start,
    output logic [WA-1:0] launch_end,
    output logic          incr,
    output logic [WA-1:0] incr_end
);
    import cfd_pkg::*;

    logic          wr_start, wr_end, wr_ctrl, hold;
    logic [WA-1:0] wr_addr;

    // decode the write strobe into per-register writes
    always_comb begin
        wr_start = cfg_we && (cfg_sel == SEL_START);
        wr_end   = cfg_we && (cfg_sel == SEL_END);
        wr_ctrl  = cfg_we && (cfg_sel == SEL_CTRL);
        wr_addr  = cfg_wdata[AW-1:LSB];
        hold     = freeze || flush;
    end

    // launch, incremental-extend and their address operands
    always_comb begin
        launch       = start_pend && !running && !hold && (wr_end || end_pend);
        launch_start = start_w;
        launch_end   = wr_end ? wr_addr : end_w;
        incr         = wr_end && !start_pend;
        incr_end     = wr_addr;
    end

    // address registers: last written start and end values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_w <= '0;
            end_w   <= '0;
        end else begin
            if (wr_start) start_w <= wr_addr;
            if (wr_end)   end_w   <= wr_addr;
        end
    end

    // pending flags: a start write arms, a launch consumes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_pend <= 1'b0;
            end_pend   <= 1'b0;
        end else begin
            if (wr_start)    start_pend <= 1'b1;
            else if (launch) start_pend <= 1'b0;
            if (launch)                       end_pend <= 1'b0;
            else if (wr_end && start_pend)    end_pend <= 1'b1;
        end
    end

    // control bits with set-over-clear priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            freeze <= 1'b0;
            flush  <= 1'b0;
            src    <= 1'b0;
        end else if (wr_ctrl) begin
            if (cfg_wdata[CB_SRC_SET])      src <= 1'b1;
            else if (cfg_wdata[CB_SRC_CLR]) src <= 1'b0;
            if (cfg_wdata[CB_FRZ_SET])      freeze <= 1'b1;
            else if (cfg_wdata[CB_FRZ_CLR]) freeze <= 1'b0;
            if (cfg_wdata[CB_FLS_SET])      flush <= 1'b1;
            else if (cfg_wdata[CB_FLS_CLR]) flush <= 1'b0;
        end
    end
endmodule

// File: rtl/cfd_engine.sv
// Fetch address engine. Keeps the current word address and the active
// (exclusive) end, issues one word request per cycle while the transfer
// runs and is not held, and advances on each accepted word.
// Assumes the memory returns data in the same cycle it acknowledges.
module cfd_engine #(
    parameter int WA = cfd_pkg::ADDR_W - cfd_pkg::ALIGN_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  logic [WA-1:0] launch_start,
    input  logic [WA-1:0] launch_end,
    input  logic          incr,
    input  logic [WA-1:0] incr_end,
    input  logic          freeze,
    input  logic          flush,
    input  logic          fifo_full,
    input  logic          port_ack,
    output logic [WA-1:0] cur_w,
    output logic          running,
    output logic          busy,
    output logic          req,
    output logic          accept
);
    logic [WA-1:0] act_w;

    // transfer state and request qualification
    always_comb begin
        running = cur_w < act_w;
        busy    = running && !freeze && !flush;
        req     = busy && !fifo_full;
        accept  = req && port_ack;
    end

    // current/end pointers: flush truncates, launch reloads, else step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_w <= '0;
            act_w <= '0;
        end else if (flush) begin
            act_w <= cur_w;
        end else if (launch) begin
            cur_w <= launch_start;
            act_w <= launch_end;
        end else begin
            if (incr)   act_w <= incr_end;
            if (accept) cur_w <= cur_w + 1'b1;
        end
    end
endmodule

// File: rtl/cfd_srcmux.sv
// Routes the fetch request to the selected memory port and returns that
// port's acknowledge and data. One port per source, built by generate.
module cfd_srcmux #(
    parameter int NSRC = cfd_pkg::N_SRC,
    parameter int DW   = cfd_pkg::WORD_W,
    localparam int SW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [SW-1:0]      src,
    input  logic               req,
    output logic [NSRC-1:0]    mem_req,
    input  logic [NSRC-1:0]    mem_ack,
    input  logic [NSRC*DW-1:0] mem_rdata,
    output logic               ack_sel,
    output logic [DW-1:0]      data_sel
);
    // per-port request steering
    for (genvar g = 0; g < NSRC; g++) begin : g_port
        assign mem_req[g] = req && (src == SW'(g));
    end

    // return path from the selected port
    always_comb begin
        ack_sel  = 1'b0;
        data_sel = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (src == SW'(i)) begin
                ack_sel  = mem_ack[i];
                data_sel = mem_rdata[i*DW +: DW];
            end
        end
    end
endmodule

// File: rtl/cmd_fetch_dma.sv
// Double-buffered command fetch DMA top. Connects the register file,
// the fetch engine and the source multiplexer, and forms the readbacks
// with the discarded alignment bits shown as zero.
module cmd_fetch_dma #(
    parameter int AW  = cfd_pkg::ADDR_W,
    parameter int DW  = cfd_pkg::WORD_W,
    parameter int LSB = cfd_pkg::ALIGN_W,
    localparam int WA = AW - LSB
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    output logic [AW-1:0] start_rd,
    output logic [AW-1:0] end_rd,
    output logic [AW-1:0] cur_rd,
    output logic          start_pending,
    output logic          end_pending,
    output logic          dma_busy,
    output logic          freeze_st,
    output logic          flush_st,
    output logic          src_st,
    output logic [1:0]    mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic [1:0]    mem_ack,
    input  logic [DW-1:0] mem_rdata_a,
    input  logic [DW-1:0] mem_rdata_b,
    input  logic          fifo_full,
    output logic          fifo_push,
    output logic [DW-1:0] fifo_wdata
);
    logic [WA-1:0] start_w, end_w, cur_w, launch_start, launch_end, incr_end;
    logic          launch, incr, running, busy, req, accept, port_ack;
    logic          freeze, flush, src;

    cfd_regfile #(.AW(AW), .LSB(LSB)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .running(running),
        .start_w(start_w), .end_w(end_w),
        .start_pend(start_pending), .end_pend(end_pending),
        .freeze(freeze), .flush(flush), .src(src),
        .launch(launch), .launch_start(launch_start), .launch_end(launch_end),
        .incr(incr), .incr_end(incr_end)
    );

    cfd_engine #(.WA(WA)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .launch(launch), .launch_start(launch_start), .launch_end(launch_end),
        .incr(incr), .incr_end(incr_end),
        .freeze(freeze), .flush(flush),
        .fifo_full(fifo_full), .port_ack(port_ack),
        .cur_w(cur_w), .running(running), .busy(busy),
        .req(req), .accept(accept)
    );

    cfd_srcmux #(.NSRC(2), .DW(DW)) u_mux (
        .src(src), .req(req),
        .mem_req(mem_req), .mem_ack(mem_ack),
        .mem_rdata({mem_rdata_b, mem_rdata_a}),
        .ack_sel(port_ack), .data_sel(fifo_wdata)
    );

    // readbacks and outward status
    always_comb begin
        start_rd  = {start_w, {LSB{1'b0}}};
        end_rd    = {end_w,   {LSB{1'b0}}};
        cur_rd    = {cur_w,   {LSB{1'b0}}};
        mem_addr  = cur_rd;
        dma_busy  = busy;
        freeze_st = freeze;
        flush_st  = flush;
        src_st    = src;
        fifo_push = accept;
    end
endmodule

// File: rtl/cfd_checker.sv
// Temporal checks on the command fetch DMA ports, bound to the top.
module cfd_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [23:0] cur_rd,
    input logic        start_pending,
    input logic        end_pending,
    input logic        dma_busy,
    input logic        freeze_st,
    input logic        flush_st,
    input logic        src_st,
    input logic [1:0]  mem_req,
    input logic        fifo_full,
    input logic        fifo_push
);
    p_push_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |=> cur_rd == $past(cur_rd) + 24'd8);

    p_queue_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
        end_pending |-> start_pending);

    p_freeze_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        freeze_st |-> (!fifo_push && mem_req == 2'b00));

    p_freeze_cur_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze_st && !flush_st && !$rose(freeze_st)) |-> $stable(cur_rd));

    p_flush_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush_st |-> (!dma_busy && !fifo_push));

    p_full_noreq_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> mem_req == 2'b00);

    p_one_port_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mem_req) && (mem_req[src_st ? 0 : 1] == 1'b0));

    p_req_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (|mem_req) |-> dma_busy);
endmodule

bind cmd_fetch_dma cfd_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cur_rd(cur_rd),
    .start_pending(start_pending), .end_pending(end_pending),
    .dma_busy(dma_busy), .freeze_st(freeze_st), .flush_st(flush_st),
    .src_st(src_st), .mem_req(mem_req), .fifo_full(fifo_full),
    .fifo_push(fifo_push)
);

// File: tb/cmd_fetch_dma_tb.sv
module cmd_fetch_dma_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd3;
    logic [23:0] cfg_wdata = '0;
    logic [23:0] start_rd, end_rd, cur_rd, mem_addr;
    logic        start_pending, end_pending, dma_busy, freeze_st, flush_st, src_st;
    logic [1:0]  mem_req;
    logic [1:0]  mem_ack = 2'b00;
    logic [63:0] mem_rdata_a, mem_rdata_b, fifo_wdata;
    logic        fifo_full = 1'b0;
    logic        fifo_push;

    int n_chk = 0;
    int n_bad = 0;
    int n_push = 0;
    logic [63:0] last_word = '0;
    bit done = 0;

    always #4 clk = ~clk;

    // memory model: each port tags its words and echoes the address
    assign mem_rdata_a = {8'hAA, 32'h0, mem_addr};
    assign mem_rdata_b = {8'hBB, 32'h0, mem_addr};

    cmd_fetch_dma u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .start_rd(start_rd), .end_rd(end_rd),
        .cur_rd(cur_rd), .start_pending(start_pending), .end_pending(end_pending),
        .dma_busy(dma_busy), .freeze_st(freeze_st), .flush_st(flush_st),
        .src_st(src_st), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata_a(mem_rdata_a), .mem_rdata_b(mem_rdata_b),
        .fifo_full(fifo_full), .fifo_push(fifo_push), .fifo_wdata(fifo_wdata)
    );

    // FIFO-side monitor
    always @(posedge clk) begin
        if (rst_n && fifo_push) begin
            n_push    <= n_push + 1;
            last_word <= fifo_wdata;
        end
    end

    typedef struct packed {
        logic [1:0]  sel;
        logic [23:0] data;
        logic [23:0] e_start;
        logic [23:0] e_end;
        logic [23:0] e_cur;
        logic        e_sp;
        logic        e_ep;
        logic        e_busy;
    } vec_t;

    // register write sequence with memory acks held low
    localparam vec_t TBL [0:7] = '{
        '{2'd0, 24'h000105, 24'h000100, 24'h000000, 24'h000000, 1'b1, 1'b0, 1'b0},
        '{2'd0, 24'h000200, 24'h000200, 24'h000000, 24'h000000, 1'b1, 1'b0, 1'b0},
        '{2'd1, 24'h000240, 24'h000200, 24'h000240, 24'h000200, 1'b0, 1'b0, 1'b1},
        '{2'd0, 24'h000800, 24'h000800, 24'h000240, 24'h000200, 1'b1, 1'b0, 1'b1},
        '{2'd1, 24'h000840, 24'h000800, 24'h000840, 24'h000200, 1'b1, 1'b1, 1'b1},
        '{2'd1, 24'h00088F, 24'h000800, 24'h000888, 24'h000200, 1'b1, 1'b1, 1'b1},
        '{2'd2, 24'h000004, 24'h000800, 24'h000888, 24'h000200, 1'b1, 1'b1, 1'b0},
        '{2'd2, 24'h000008, 24'h000800, 24'h000888, 24'h000200, 1'b1, 1'b1, 1'b1}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [23:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0; cfg_sel = 2'd3;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        idle(3);
        // R1: reset state
        chk("R1 start", start_rd, 0);
        chk("R1 end", end_rd, 0);
        chk("R1 cur", cur_rd, 0);
        chk("R1 flags", {start_pending, end_pending, dma_busy, freeze_st, flush_st, src_st, mem_req}, 0);
        rst_n = 1'b1;

        // table walk: R2 R3 R4 R7 R8 R9 R12
        for (int i = 0; i < 8; i++) begin
            wr(TBL[i].sel, TBL[i].data);
            chk($sformatf("R8 start row %0d", i), start_rd, TBL[i].e_start);
            chk($sformatf("R8 end row %0d", i), end_rd, TBL[i].e_end);
            chk($sformatf("R4 cur row %0d", i), cur_rd, TBL[i].e_cur);
            chk($sformatf("R7 pend row %0d", i), {start_pending, end_pending}, {TBL[i].e_sp, TBL[i].e_ep});
            chk($sformatf("R12 busy row %0d", i), dma_busy, TBL[i].e_busy);
        end

        do_reset();
        chk("R1 after reset", {start_rd, end_rd, cur_rd, start_pending, end_pending, dma_busy}, 0);

        // R5: plain transfer from port 0, exclusive end
        mem_ack = 2'b11;
        wr(2'd0, 24'h001000);
        idle(2);
        chk("R3 no fetch on start", {n_push, cur_rd}, {32'd0, 24'h000000});
        wr(2'd1, 24'h001020);
        idle(10);
        chk("R5 count", n_push, 4);
        chk("R5 last word", last_word, {8'hAA, 32'h0, 24'h001018});
        chk("R5 cur at end", cur_rd, 24'h001020);
        chk("R12 idle", dma_busy, 0);

        // R6: incremental extension
        wr(2'd1, 24'h001030);
        idle(8);
        chk("R6 count", n_push, 6);
        chk("R6 cur", cur_rd, 24'h001030);

        // R4: zero-length transfer
        wr(2'd0, 24'h002000);
        wr(2'd1, 24'h002000);
        idle(4);
        chk("R4 zero cur", cur_rd, 24'h002000);
        chk("R4 zero nopush", n_push, 6);
        chk("R4 zero flags", {start_pending, dma_busy}, 2'b00);

        // R11: switch to port 1, extend the empty transfer
        wr(2'd2, 24'h000001);
        wr(2'd1, 24'h002010);
        idle(6);
        chk("R11 src count", n_push, 8);
        chk("R11 src word", last_word, {8'hBB, 32'h0, 24'h002008});

        // R11 backpressure: full FIFO stalls without dropping busy
        fifo_full = 1'b1;
        wr(2'd1, 24'h002020);
        idle(5);
        chk("R11 full cur", cur_rd, 24'h002010);
        chk("R11 full req", {mem_req, n_push}, {2'b00, 32'd8});
        chk("R12 busy while full", dma_busy, 1);
        fifo_full = 1'b0;
        idle(6);
        chk("R11 drain", {n_push, cur_rd}, {32'd10, 24'h002020});

        // R9: freeze, writes during freeze, resume and auto hand-off (R7)
        wr(2'd2, 24'h000004);
        wr(2'd1, 24'h002040);
        idle(4);
        chk("R9 frozen cur", cur_rd, 24'h002020);
        chk("R9 frozen busy", {dma_busy, n_push}, {1'b0, 32'd10});
        wr(2'd0, 24'h003000);
        wr(2'd1, 24'h003008);
        wr(2'd1, 24'h003010);
        chk("R9 flags during freeze", {start_pending, end_pending}, 2'b11);
        chk("R9 no launch", cur_rd, 24'h002020);
        wr(2'd2, 24'h000008);
        idle(15);
        chk("R7 handoff count", n_push, 16);
        chk("R7 handoff end", cur_rd, 24'h003010);
        chk("R7 flags clear", {start_pending, end_pending}, 2'b00);
        chk("R7 last word", last_word, {8'hBB, 32'h0, 24'h003008});

        // R10: flush truncates and blocks a queued transfer
        fifo_full = 1'b1;
        wr(2'd1, 24'h003040);
        chk("R12 busy before flush", dma_busy, 1);
        wr(2'd2, 24'h000010);
        fifo_full = 1'b0;
        idle(4);
        chk("R10 no progress", {dma_busy, n_push, cur_rd}, {1'b0, 32'd16, 24'h003010});
        wr(2'd0, 24'h004000);
        wr(2'd1, 24'h004010);
        idle(3);
        chk("R10 queued held", {start_pending, end_pending, cur_rd}, {2'b11, 24'h003010});
        wr(2'd2, 24'h000020);
        idle(8);
        chk("R10 resume queued", {n_push, cur_rd}, {32'd18, 24'h004010});
        chk("R10 flags clear", {start_pending, end_pending, flush_st}, 3'b000);

        finish_run();
    end
endmodule